// File: doc/BRIEF.md
# Eight-Input Prioritized Interrupt Controller

This block collects interrupt events from eight sources and holds them in a pending register. It offers the CPU the most urgent request that may run now. Each source can raise its bit in three ways: a rising edge on an external pin, a one-cycle pulse from an on-chip peripheral, or a software write to a set-pending register. Software can also drop pending bits one at a time through a separate clear-pending register. Neither register needs a read-modify-write sequence.

Requests nest. When the CPU accepts a request, the pending bit is cleared and the level of the request is pushed onto an active-level stack. Only a request with a strictly higher index can then preempt the running handler. A return-from-interrupt pops the stack. Each source also has a flag that ranks it above or below the CPU's high-priority task level. A source ranked below that level waits while the CPU reports that a high-priority task is running.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending, enable and above-task-level registers are zero, the active stack is empty and `irq_req` is low.
- R2: A pending bit is set by a write of 1 to that bit at address 2, by a one-cycle pulse on `irq_periph`, or by a rising edge on `irq_pin`. A pin that rises before a clock edge shows up as pending after the third rising clock edge. A pin held high sets its bit only once.
- R3: Writing 1 to a bit at address 3 clears that pending bit. If a set event and a clear fall on the same bit in the same cycle, the set wins.
- R4: `irq_req` is high when at least one source is eligible, and `irq_id` then gives the highest eligible index. Index 7 is the most urgent and index 0 the least.
- R5: A pending source whose enable bit (address 0) is 0 is not requested, and its pending bit is kept.
- R6: While the active stack is not empty, a source is eligible only if its index is strictly greater than the level on top of the stack.
- R7: A source whose flag at address 1 is 0 ranks below the task level and is not eligible while `cpu_hipri_busy` is high. A flag of 1 ranks the source above the task level, and `cpu_hipri_busy` does not block it.
- R8: When `irq_ack` is high with `irq_req`, the pending bit of `irq_id` clears and `irq_id` is pushed on the stack. An acknowledge without a request has no effect. A set event for the granted source in the acknowledge cycle leaves its bit pending.
- R9: A pulse on `irq_ret` pops the stack, and a pulse on an empty stack is ignored. When `irq_ack` and `irq_ret` fall in the same cycle, the granted level replaces the top entry, so the depth stays the same. The stack holds eight levels.
- R10: Reads return the enable register at address 0, the flags at address 1 and the pending register at address 4. Address 5 returns the stack state: bit 3 is set when the stack is not empty, and bits 2:0 give the top level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin | input | 8 | Asynchronous external interrupt pins; each rising edge is an event |
| irq_periph | input | 8 | Synchronous one-cycle event pulses from peripherals |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cpu_hipri_busy | input | 1 | CPU is running a high-priority task |
| irq_req | output | 1 | An eligible request is offered |
| irq_id | output | 3 | Index of the offered request |
| irq_ack | input | 1 | CPU accepts the offered request |
| irq_ret | input | 1 | CPU returns from the current handler |

## Verification
Two functions can meet in one cycle: clearing a pending bit, by software or by an acknowledge, and a new set event on that same bit. The bench pulses `irq_periph` in the cycle of a clear-pending write, and again in the cycle of an acknowledge. It then reads the pending register and expects the bit still set. A second collision is an acknowledge paired with a return. There the bench checks that the stack depth stays the same, that the top level changes to the granted level, and that one further return empties the stack.

// File: rtl/irq_pkg.sv
// Package: shared register map for the interrupt controller.
// Assumes a 3-bit register address.
package irq_pkg;

    typedef enum logic [2:0] {
        REG_ENABLE = 3'd0,
        REG_ABOVE  = 3'd1,
        REG_SETP   = 3'd2,
        REG_CLRP   = 3'd3,
        REG_PEND   = 3'd4,
        REG_LEVEL  = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/irq_edge_sync.sv
// Module: synchronizes asynchronous pins through STAGES flip-flops and
// emits a one-cycle pulse on each rising edge of the synchronized value.
// Assumes STAGES >= 2.
module irq_edge_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] shreg;
        logic              prev;

        // Shift the pin through the synchronizer and keep the last value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '0;
                prev  <= 1'b0;
            end else begin
                shreg <= {shreg[STAGES-2:0], pin[g]};
                prev  <= shreg[STAGES-1];
            end
        end

        assign rise[g] = shreg[STAGES-1] & ~prev;
    end

endmodule

// File: rtl/irq_pending.sv
// Module: pending register. Set events win over clears in the same cycle.
// Assumes set, clear and ack masks are synchronous to clk.
module irq_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] pend
);

    // Apply the clears, then the sets, to every pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask & ~ack_mask) | set_mask;
    end

endmodule

// File: rtl/irq_level_stack.sv
// Module: stack of active handler levels. A push with a pop replaces the top.
// Assumes pushes only carry strictly increasing levels, so N entries suffice.
module irq_level_stack #(
    parameter int N    = 8,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [ID_W-1:0] push_lvl,
    output logic            nonempty,
    output logic [ID_W-1:0] top,
    output logic [ID_W:0]   depth
);

    logic [ID_W-1:0] mem [N];
    logic [ID_W-1:0] top_idx;
    logic [ID_W-1:0] push_idx;

    assign nonempty = (depth != '0);
    assign top_idx  = ID_W'(depth - 1'b1);
    assign push_idx = ID_W'(depth);
    assign top      = nonempty ? mem[top_idx] : '0;

    // Update the stack entries and the depth on push, pop or replace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (push && pop && nonempty) begin
            mem[top_idx] <= push_lvl;
        end else if (push && (depth < (ID_W+1)'(N))) begin
            mem[push_idx] <= push_lvl;
            depth         <= depth + 1'b1;
        end else if (pop && nonempty) begin
            depth <= depth - 1'b1;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Module: selects the highest eligible index among pending requests.
// Assumes a higher index means a more urgent request.
module irq_arbiter #(
    parameter int N    = 8,
    parameter int ID_W = 3
) (
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    en,
    input  logic [N-1:0]    above,
    input  logic            busy,
    input  logic            nonempty,
    input  logic [ID_W-1:0] top,
    output logic            req,
    output logic [ID_W-1:0] id
);

    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = pend[g] & en[g] & (above[g] | ~busy) &
                         (~nonempty | (ID_W'(g) > top));
    end

    // Scan upward so that the highest eligible index is the one kept.
    always_comb begin
        id = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) id = ID_W'(i);
        end
    end

    assign req = |elig;

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt controller. Holds the bus
// registers, merges the event sources and connects the pending register,
// the arbiter and the level stack.
// Assumes irq_periph pulses are synchronous to clk and irq_pin is not.
module irq_prio_ctrl #(
    parameter int N_IRQ       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ID_W       = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_pin,
    input  logic [N_IRQ-1:0] irq_periph,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wen,
    input  logic [N_IRQ-1:0] bus_wdata,
    output logic [N_IRQ-1:0] bus_rdata,
    input  logic             cpu_hipri_busy,
    output logic             irq_req,
    output logic [ID_W-1:0]  irq_id,
    input  logic             irq_ack,
    input  logic             irq_ret
);
    import irq_pkg::*;

    logic [N_IRQ-1:0] en_q;
    logic [N_IRQ-1:0] above_q;
    logic [N_IRQ-1:0] pend;
    logic [N_IRQ-1:0] pin_rise;
    logic [N_IRQ-1:0] sw_set;
    logic [N_IRQ-1:0] sw_clr;
    logic [N_IRQ-1:0] set_mask;
    logic [N_IRQ-1:0] ack_mask;
    logic             grant;
    logic             stk_nonempty;
    logic [ID_W-1:0]  stk_top;
    logic [ID_W:0]    stk_depth;
    reg_addr_e        addr_e;

    assign addr_e = reg_addr_e'(bus_addr);

    // Hold the enable and above-task-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            above_q <= '0;
        end else if (bus_wen) begin
            if (addr_e == REG_ENABLE) en_q    <= bus_wdata;
            if (addr_e == REG_ABOVE)  above_q <= bus_wdata;
        end
    end

    assign sw_set   = (bus_wen && addr_e == REG_SETP) ? bus_wdata : '0;
    assign sw_clr   = (bus_wen && addr_e == REG_CLRP) ? bus_wdata : '0;
    assign set_mask = pin_rise | irq_periph | sw_set;
    assign grant    = irq_req & irq_ack;
    assign ack_mask = grant ? (N_IRQ'(1) << irq_id) : '0;

    irq_edge_sync #(.N(N_IRQ), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (irq_pin),
        .rise (pin_rise)
    );

    irq_pending #(.N(N_IRQ)) i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(sw_clr),
        .ack_mask(ack_mask),
        .pend    (pend)
    );

    irq_arbiter #(.N(N_IRQ), .ID_W(ID_W)) i_arb (
        .pend    (pend),
        .en      (en_q),
        .above   (above_q),
        .busy    (cpu_hipri_busy),
        .nonempty(stk_nonempty),
        .top     (stk_top),
        .req     (irq_req),
        .id      (irq_id)
    );

    irq_level_stack #(.N(N_IRQ), .ID_W(ID_W)) i_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (grant),
        .pop     (irq_ret),
        .push_lvl(irq_id),
        .nonempty(stk_nonempty),
        .top     (stk_top),
        .depth   (stk_depth)
    );

    // Return the register selected by the address.
    always_comb begin
        bus_rdata = '0;
        case (addr_e)
            REG_ENABLE: bus_rdata = en_q;
            REG_ABOVE:  bus_rdata = above_q;
            REG_PEND:   bus_rdata = pend;
            REG_LEVEL:  bus_rdata = N_IRQ'({stk_nonempty, stk_top});
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module: checker bound to irq_prio_ctrl. It relates the offered request
// to the pending, enable, flag and stack state.
module irq_prio_ctrl_chk #(
    parameter int N_IRQ = 8,
    parameter int ID_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic [ID_W-1:0]  irq_id,
    input logic             irq_ack,
    input logic             irq_ret,
    input logic             cpu_hipri_busy,
    input logic [N_IRQ-1:0] pend,
    input logic [N_IRQ-1:0] en_q,
    input logic [N_IRQ-1:0] above_q,
    input logic [N_IRQ-1:0] set_mask,
    input logic             stk_nonempty,
    input logic [ID_W-1:0]  stk_top,
    input logic [ID_W:0]    stk_depth
);

    // R4
    req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend[irq_id] && en_q[irq_id]));

    // R6
    preempt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && stk_nonempty) |-> (irq_id > stk_top));

    // R7
    task_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_hipri_busy) |-> above_q[irq_id]);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !set_mask[irq_id]) |=> !pend[$past(irq_id)]);

    // R8
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !irq_ret) |=> (stk_nonempty && stk_top == $past(irq_id)));

    // R9
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && stk_nonempty) |=> (stk_depth == $past(stk_depth) - 1'b1));

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= (ID_W+1)'(N_IRQ));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_IRQ(N_IRQ), .ID_W(ID_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req       (irq_req),
    .irq_id        (irq_id),
    .irq_ack       (irq_ack),
    .irq_ret       (irq_ret),
    .cpu_hipri_busy(cpu_hipri_busy),
    .pend          (pend),
    .en_q          (en_q),
    .above_q       (above_q),
    .set_mask      (set_mask),
    .stk_nonempty  (stk_nonempty),
    .stk_top       (stk_top),
    .stk_depth     (stk_depth)
);

// File: tb/test_irq_prio_ctrl.sv
// Directed bench for irq_prio_ctrl; each task checks its own scenario.
module test_irq_prio_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pin = '0;
    logic [7:0] irq_periph = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wen = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_hipri_busy = 1'b0;
    logic       irq_req;
    logic [2:0] irq_id;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_periph(irq_periph),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_hipri_busy(cpu_hipri_busy),
        .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        step();
        bus_wen = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 req", int'(irq_req), 0);
        rd(3'd0, d); check("R1 enable", d, 0);
        rd(3'd1, d); check("R1 above", d, 0);
        rd(3'd4, d); check("R1 pending", d, 0);
        rd(3'd5, d); check("R1 level", d, 0);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        rd(3'd0, d); check("R10 enable read", d, 8'hFF);
        wr(3'd2, 8'h24);
        check("R4 req", int'(irq_req), 1);
        check("R4 id highest", int'(irq_id), 5);
        rd(3'd4, d); check("R2/R10 sw set pending", d, 8'h24);
        wr(3'd3, 8'h20);
        check("R3 id after clear", int'(irq_id), 2);
        wr(3'd3, 8'h04);
        check("R3 req after clear", int'(irq_req), 0);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(3'd0, 8'h0F); wr(3'd2, 8'h80);
        check("R5 disabled no req", int'(irq_req), 0);
        rd(3'd4, d); check("R5 kept pending", d, 8'h80);
        wr(3'd2, 8'h02);
        check("R5 enabled id", int'(irq_id), 1);
        wr(3'd0, 8'hFF);
        check("R5 re-enabled id", int'(irq_id), 7);
        wr(3'd3, 8'hFF);
    endtask

    task automatic t_pin();
        logic [7:0] d;
        irq_pin[3] = 1'b1;
        step(); step();
        rd(3'd4, d); check("R2 pin not yet", d, 0);
        step();
        rd(3'd4, d); check("R2 pin third edge", d, 8'h08);
        wr(3'd3, 8'h08);
        step(); step(); step();
        rd(3'd4, d); check("R2 held pin no retrigger", d, 0);
        irq_pin[3] = 1'b0;
        step(); step(); step();
    endtask

    task automatic t_periph_vs_clear();
        logic [7:0] d;
        irq_periph[6] = 1'b1; step(); irq_periph[6] = 1'b0;
        rd(3'd4, d); check("R2 periph pulse", d, 8'h40);
        wr(3'd3, 8'h40);
        irq_periph[2] = 1'b1;
        wr(3'd3, 8'h04);
        irq_periph[2] = 1'b0;
        rd(3'd4, d); check("R3 set wins over clear", d, 8'h04);
        wr(3'd3, 8'hFF);
    endtask

    task automatic t_nest();
        logic [7:0] d;
        ack();
        rd(3'd5, d); check("R8 ack without req", d, 0);
        wr(3'd2, 8'h08); ack();
        rd(3'd5, d); check("R8 push level 3", d, 8'h0B);
        rd(3'd4, d); check("R8 pending cleared", d, 0);
        wr(3'd2, 8'h04);
        check("R6 lower blocked", int'(irq_req), 0);
        wr(3'd2, 8'h20);
        check("R6 higher preempts", int'(irq_id), 5);
        ack();
        rd(3'd5, d); check("R6 nested level 5", d, 8'h0D);
        ret();
        rd(3'd5, d); check("R9 pop to level 3", d, 8'h0B);
        check("R9 still blocked", int'(irq_req), 0);
        ret();
        rd(3'd5, d); check("R9 empty", d, 0);
        check("R9 lower now offered", int'(irq_id), 2);
        ack(); ret(); ret();
        rd(3'd5, d); check("R9 pop on empty ignored", d, 0);
    endtask

    task automatic t_ack_collide();
        logic [7:0] d;
        wr(3'd2, 8'h10);
        irq_periph[4] = 1'b1; ack(); irq_periph[4] = 1'b0;
        rd(3'd4, d); check("R8 event in ack cycle kept", d, 8'h10);
        rd(3'd5, d); check("R8 level 4 pushed", d, 8'h0C);
        ret(); wr(3'd3, 8'hFF);
        wr(3'd2, 8'h02); ack();
        wr(3'd2, 8'h40);
        irq_ret = 1'b1; ack(); irq_ret = 1'b0;
        rd(3'd5, d); check("R9 ack+ret replaces top", d, 8'h0E);
        ret();
        rd(3'd5, d); check("R9 depth kept by replace", d, 0);
    endtask

    task automatic t_task_level();
        wr(3'd1, 8'h0F);
        cpu_hipri_busy = 1'b1;
        wr(3'd2, 8'h40);
        check("R7 below-level blocked", int'(irq_req), 0);
        wr(3'd2, 8'h04);
        check("R7 above-level offered", int'(irq_id), 2);
        cpu_hipri_busy = 1'b0;
        #0.5;
        check("R7 released", int'(irq_id), 6);
        wr(3'd3, 8'hFF); wr(3'd1, 8'hFF);
    endtask

    task automatic t_deep();
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            wr(3'd2, 8'(1 << i));
            ack();
        end
        rd(3'd5, d); check("R9 eight levels top 7", d, 8'h0F);
        for (int i = 0; i < 7; i++) ret();
        rd(3'd5, d); check("R9 bottom level 0", d, 8'h08);
        ret();
        rd(3'd5, d); check("R9 all popped", d, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst_n = 1'b1;
                step();
                t_reset();
                t_priority();
                t_enable();
                t_pin();
                t_periph_vs_clear();
                t_nest();
                t_ack_collide();
                t_task_level();
                t_deep();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule